// File: doc/BRIEF.md
# Security Fuse Burn Sequencer

This block guards the one-time programming of two security fuses. A fuse
burn only starts after a short, ordered register conversation. First an
unlock key goes to the setup register. Next a fuse-select code goes to the
same register. Last a fire code goes to the pulse register. The fire code
then holds a burn pulse on the chosen fuse until software writes any other
value to the pulse register. Software times the pulse, typically for about
half a millisecond, and then writes zero.

The mode-1 fuse may only be burned while an external security pin is high.
The mode-0 fuse ignores that pin. A synchronised copy of the pin is readable
as a status bit. Each fuse is modelled as a sticky flop plus a burn-time
counter. The flop is marked blown only after the pulse has stayed on for
`MIN_BURN` consecutive clock cycles. Once blown, it stays blown through
circuit reset.

A blown mode-0 fuse is the precondition for software to enter security
mode 0. A blown mode-1 fuse permanently disables the debug port. A fire
command that arrives out of order, or without a permitted selection, does
not burn anything. Instead it sets a sticky error flag.

FSM states: `ST_IDLE` (waiting for the key), `ST_ARMED` (key seen),
`ST_CHOSEN` (one fuse selected) and `ST_BURN` (pulse active).

Transitions:
- A setup write of the key goes to `ST_ARMED` from any state.
- In `ST_ARMED`, a setup write of a select code goes to `ST_CHOSEN`.
- Every other setup write goes to `ST_IDLE`.
- A fire write moves `ST_CHOSEN` to `ST_BURN`, unless it targets mode 1 while the pin is low; that case goes to `ST_IDLE` with an error.
- A fire write in `ST_IDLE` or `ST_ARMED` goes to `ST_IDLE` with an error.
- A non-fire pulse write moves `ST_BURN` to `ST_IDLE`.
- In `ST_BURN` on mode 1, a low pin moves to `ST_IDLE`.

Top module: `fuse_burn_seq`

## Requirements
- R1: A setup write (wr_sel=0) of 0x54 arms the sequencer from any state. Any setup write that is neither the key nor a valid selection directly after the key returns it to idle.
- R2: Only the setup write immediately following the key selects a fuse: 0x81 selects mode 0 and 0x82 selects mode 1. A further setup write after selection ends the sequence, so one sequence burns at most one fuse.
- R3: A pulse write (wr_sel=1) of 0xA6 in the selected state raises the burn bit of the chosen fuse from the next cycle (burn_pulse[0] for mode 0, burn_pulse[1] for mode 1). A repeated 0xA6 keeps it on. Any other pulse value, or any setup write, ends the burn. A non-0xA6 pulse write outside a burn has no effect.
- R4: At most one bit of burn_pulse is high in any cycle.
- R5: A mode-1 burn starts only while pin_level is high. A fire write for mode 1 with pin_level low burns nothing and sets seq_err. Pin_level falling during a mode-1 burn ends it. A mode-0 burn does not depend on the pin.
- R6: pin_level follows sec_pin after SYNC_STAGES clock edges.
- R7: A set fuse_blown bit stays set. rst_n does not clear it; only pwr_on_n (the model's unprogrammed state) does.
- R8: seq_err is set by a fire write that arrives without a completed key-and-select sequence, or by a refused mode-1 fire. It stays set until rst_n.
- R9: A fuse_blown bit sets only after its burn bit has been high for MIN_BURN consecutive cycles. Shorter pulses do not add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Circuit reset, active low; leaves fuse state alone |
| pwr_on_n | input | 1 | Model-only initialisation of the fuse array to unblown, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Target register: 0 setup, 1 pulse |
| wr_data | input | 8 | Written value |
| sec_pin | input | 1 | External security pin, asynchronous |
| pin_level | output | 1 | Synchronised security pin status |
| burn_pulse | output | 2 | Burn drive, bit 0 mode-0 fuse, bit 1 mode-1 fuse |
| fuse_blown | output | 2 | Sticky fuse status, bit 0 mode-0, bit 1 mode-1 |
| seq_err | output | 1 | Sticky sequence error |

## Verification
The properties assume that writes are single-cycle strobes with stable data. They also assume that pwr_on_n is asserted only at the very start, together with rst_n, so the fuse flops and the state machine leave reset from a known point. The stimulus drives every write on the falling edge for exactly one cycle. It changes sec_pin only between writes and waits several cycles for the synchroniser before relying on the new level. It releases pwr_on_n once, and never again, while rst_n is pulsed repeatedly to show that fuse state survives it.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_CHOSEN = 2'd2,
        ST_BURN   = 2'd3
    } seq_state_t;

    localparam int          NUM_FUSES  = 2;
    localparam logic [7:0]  KEY_UNLOCK = 8'h54;
    localparam logic [7:0]  KEY_SEL0   = 8'h81;
    localparam logic [7:0]  KEY_SEL1   = 8'h82;
    localparam logic [7:0]  KEY_FIRE   = 8'hA6;
endpackage

// File: rtl/fuse_pin_sync.sv
module fuse_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else begin
                    if (g == 0) chain[g] <= pin_async;
                    else        chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/fuse_seq_fsm.sv
module fuse_seq_fsm
    import fuse_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [7:0]           wr_data,
    input  logic                 pin_ok,
    output logic [NUM_FUSES-1:0] burn_vec,
    output logic                 seq_err
);
    seq_state_t state, state_nxt;
    logic       sel_q, sel_nxt;
    logic       err_q, err_set;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            state <= state_nxt;
            sel_q <= sel_nxt;
            if (err_set) err_q <= 1'b1;
        end
    end

    // next-state decision
    always_comb begin
        state_nxt = state;
        sel_nxt   = sel_q;
        err_set   = 1'b0;

        if (state == ST_BURN && sel_q && !pin_ok) begin
            state_nxt = ST_IDLE;
        end

        if (wr_en) begin
            if (!wr_sel) begin
                if (wr_data == KEY_UNLOCK) begin
                    state_nxt = ST_ARMED;
                end else if (state == ST_ARMED &&
                             (wr_data == KEY_SEL0 || wr_data == KEY_SEL1)) begin
                    state_nxt = ST_CHOSEN;
                    sel_nxt   = (wr_data == KEY_SEL1);
                end else begin
                    state_nxt = ST_IDLE;
                end
            end else if (wr_data == KEY_FIRE) begin
                unique case (state)
                    ST_IDLE, ST_ARMED: begin
                        state_nxt = ST_IDLE;
                        err_set   = 1'b1;
                    end
                    ST_CHOSEN: begin
                        if (sel_q && !pin_ok) begin
                            state_nxt = ST_IDLE;
                            err_set   = 1'b1;
                        end else begin
                            state_nxt = ST_BURN;
                        end
                    end
                    ST_BURN: begin
                        // repeated fire keeps the pulse unless the pin dropped
                    end
                    default: state_nxt = ST_IDLE;
                endcase
            end else if (state == ST_BURN) begin
                state_nxt = ST_IDLE;
            end
        end
    end

    // outputs
    always_comb begin
        burn_vec = '0;
        if (state == ST_BURN) begin
            if (!sel_q)      burn_vec[0] = 1'b1;
            else if (pin_ok) burn_vec[1] = 1'b1;
        end
        seq_err = err_q;
    end
endmodule

// File: rtl/fuse_cell.sv
module fuse_cell #(
    parameter int MIN_BURN = 12000
) (
    input  logic clk,
    input  logic pwr_on_n,
    input  logic burn,
    output logic blown
);
    localparam int CW = $clog2(MIN_BURN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_BURN);
    localparam logic [CW-1:0] LAST  = CW'(MIN_BURN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            cnt   <= '0;
            blown <= 1'b0;
        end else begin
            if (!burn)              cnt <= '0;
            else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
            if (burn && cnt == LAST) blown <= 1'b1;
        end
    end
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
    import fuse_seq_pkg::*;
#(
    parameter int MIN_BURN    = 12000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_on_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       sec_pin,
    output logic       pin_level,
    output logic [1:0] burn_pulse,
    output logic [1:0] fuse_blown,
    output logic       seq_err
);
    logic [NUM_FUSES-1:0] burn_int;

    fuse_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (sec_pin),
        .pin_sync  (pin_level)
    );

    fuse_seq_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .pin_ok   (pin_level),
        .burn_vec (burn_int),
        .seq_err  (seq_err)
    );

    generate
        for (genvar f = 0; f < NUM_FUSES; f++) begin : g_fuse
            fuse_cell #(.MIN_BURN(MIN_BURN)) i_cell (
                .clk      (clk),
                .pwr_on_n (pwr_on_n),
                .burn     (burn_int[f]),
                .blown    (fuse_blown[f])
            );
        end
    endgenerate

    assign burn_pulse = burn_int;
endmodule

// File: rtl/fuse_burn_seq_chk.sv
module fuse_burn_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_on_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       pin_level,
    input logic [1:0] burn_pulse,
    input logic [1:0] fuse_blown,
    input logic       seq_err
);
    // R3: a burn only starts right after a fire write to the pulse register
    a_r3_fire_starts: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        $rose(|burn_pulse) |-> $past(wr_en && wr_sel && wr_data == 8'hA6));

    // R4: never both fuses at once
    a_r4_single_burn: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        $countones(burn_pulse) <= 1);

    // R5: mode-1 burn begins only with the pin already high
    a_r5_pin_gate: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        $rose(burn_pulse[1]) |-> $past(pin_level));

    // R7: fuse bits never fall
    a_r7_fuse0_sticky: assert property (@(posedge clk) disable iff (!pwr_on_n)
        fuse_blown[0] |=> fuse_blown[0]);
    a_r7_fuse1_sticky: assert property (@(posedge clk) disable iff (!pwr_on_n)
        fuse_blown[1] |=> fuse_blown[1]);

    // R8: error flag holds until reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        seq_err |=> seq_err);

    // R9: a fuse only blows while its burn drive is on
    a_r9_blow_needs_burn0: assert property (@(posedge clk) disable iff (!pwr_on_n)
        $rose(fuse_blown[0]) |-> $past(burn_pulse[0]));
    a_r9_blow_needs_burn1: assert property (@(posedge clk) disable iff (!pwr_on_n)
        $rose(fuse_blown[1]) |-> $past(burn_pulse[1]));
endmodule

bind fuse_burn_seq fuse_burn_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_on_n   (pwr_on_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .pin_level  (pin_level),
    .burn_pulse (burn_pulse),
    .fuse_blown (fuse_blown),
    .seq_err    (seq_err)
);

// File: tb/test_fuse_burn_seq.sv
module test_fuse_burn_seq;
    localparam int MIN_B  = 16;
    localparam int NVEC   = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sec_pin = 1'b0;
    logic       pin_level;
    logic [1:0] burn_pulse;
    logic [1:0] fuse_blown;
    logic       seq_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    fuse_burn_seq #(.MIN_BURN(MIN_B), .SYNC_STAGES(2)) i_fuse_burn_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_on_n   (pwr_on_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .sec_pin    (sec_pin),
        .pin_level  (pin_level),
        .burn_pulse (burn_pulse),
        .fuse_blown (fuse_blown),
        .seq_err    (seq_err)
    );

    // {target reg, data, expected burn_pulse[1:0], expected seq_err}; pin held high
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 8'h54, 2'b00, 1'b0},   // R1 key arms
        {1'b0, 8'h81, 2'b00, 1'b0},   // R2 select mode 0
        {1'b1, 8'hA6, 2'b01, 1'b0},   // R3 fire mode 0
        {1'b1, 8'h00, 2'b00, 1'b0},   // R3 stop
        {1'b0, 8'h54, 2'b00, 1'b0},   // R1
        {1'b0, 8'h82, 2'b00, 1'b0},   // R2 select mode 1
        {1'b1, 8'hA6, 2'b10, 1'b0},   // R3 fire mode 1
        {1'b0, 8'h13, 2'b00, 1'b0},   // R3 setup write ends burn
        {1'b0, 8'h54, 2'b00, 1'b0},   // R1
        {1'b0, 8'h77, 2'b00, 1'b0},   // R1 bad select -> idle
        {1'b1, 8'h33, 2'b00, 1'b0},   // R3 non-fire outside burn ignored
        {1'b1, 8'hA6, 2'b00, 1'b1},   // R8 fire out of order
        {1'b0, 8'h54, 2'b00, 1'b1},   // R8 flag holds
        {1'b0, 8'h81, 2'b00, 1'b1},
        {1'b1, 8'hA6, 2'b01, 1'b1},   // R3
        {1'b1, 8'hA6, 2'b01, 1'b1},   // R3 repeated fire keeps pulse
        {1'b1, 8'h00, 2'b00, 1'b1}    // R3 stop
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    endtask

    task automatic burn_for(input int edges);
        wr(1'b1, 8'hA6);
        repeat (edges - 1) @(negedge clk);
        wr(1'b1, 8'h00);
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        pwr_on_n = 1'b1;
        rst_n    = 1'b1;
        @(negedge clk);
        check("R7 reset fuse_blown", fuse_blown, 0);
        check("R3 reset burn_pulse", burn_pulse, 0);
        check("R8 reset seq_err", seq_err, 0);
        check("R6 reset pin_level", pin_level, 0);

        sec_pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 pin_level high", pin_level, 1);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][11], VEC[i][10:3]);
            check($sformatf("R3 vec %0d burn", i), burn_pulse, VEC[i][2:1]);
            check($sformatf("R8 vec %0d err", i), seq_err, VEC[i][0]);
        end
        check("R9 short burns leave fuses", fuse_blown, 0);

        pulse_reset();
        check("R8 cleared by rst_n", seq_err, 0);

        // R5: mode 1 refused with pin low
        sec_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 pin_level low", pin_level, 0);
        wr(1'b0, 8'h54); wr(1'b0, 8'h82); wr(1'b1, 8'hA6);
        check("R5 mode1 pin low no burn", burn_pulse, 0);
        check("R5 mode1 pin low error", seq_err, 1);
        pulse_reset();

        // R5 mode 0 without pin; R9 one cycle short
        wr(1'b0, 8'h54); wr(1'b0, 8'h81);
        wr(1'b1, 8'hA6);
        check("R5 mode0 burns pin low", burn_pulse, 1);
        repeat (MIN_B - 2) @(negedge clk);
        wr(1'b1, 8'h00);
        check("R9 MIN_BURN-1 cycles not blown", fuse_blown, 0);

        wr(1'b0, 8'h54); wr(1'b0, 8'h81);
        burn_for(MIN_B);
        check("R9 MIN_BURN cycles blows fuse0", fuse_blown, 1);

        pulse_reset();
        check("R7 fuse survives rst_n", fuse_blown, 1);

        // R5 pin drop ends mode-1 burn
        sec_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(1'b0, 8'h54); wr(1'b0, 8'h82); wr(1'b1, 8'hA6);
        check("R5 mode1 burns pin high", burn_pulse, 2);
        sec_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 pin drop ends burn", burn_pulse, 0);
        check("R9 interrupted burn not blown", fuse_blown, 1);
        check("R5 pin drop no error", seq_err, 0);

        sec_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(1'b0, 8'h54); wr(1'b0, 8'h82);
        burn_for(MIN_B + 4);
        check("R9 fuse1 blown", fuse_blown, 3);

        // R2 second select after selection aborts
        wr(1'b0, 8'h54); wr(1'b0, 8'h81); wr(1'b0, 8'h82); wr(1'b1, 8'hA6);
        check("R2 reselect no burn", burn_pulse, 0);
        check("R2 reselect error", seq_err, 1);
        pulse_reset();

        // R1 repeated key keeps armed
        wr(1'b0, 8'h54); wr(1'b0, 8'h54); wr(1'b0, 8'h81); wr(1'b1, 8'hA6);
        check("R1 double key still arms", burn_pulse, 1);
        wr(1'b1, 8'h00);
        check("R4 idle after stop", burn_pulse, 0);
        check("R7 fuses after all", fuse_blown, 3);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule